// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block forms the unsigned product of two WIDTH-bit operands by reusing a single WIDTH-bit adder once per clock for WIDTH clocks. A pulse on `start` while the block is idle captures the multiplicand and the multiplier. The block then works through the multiplier one bit per clock, starting with its least significant bit. For each bit it either adds the multiplicand into the upper half of a double-width accumulator or leaves that half alone. It then shifts the whole accumulator one place to the right.

The upper half (`accHi`) starts at zero and gains one significant bit per step. The lower half (`accLo`) starts out holding the multiplier and gives up one multiplier bit per step to the product bits that move in from above. After the last step the concatenation `{accHi, accLo}` is the full 2·WIDTH-bit product. `done` is raised for exactly one clock at that point. The product stays on `product` until the next accepted start. A start seen while a multiplication is in progress, or during the `done` clock, is dropped.

Top module: `shift_add_mult`

## Requirements
- R1: While reset is held and right after it, `product` reads zero and `done` is low.
- R2: A `start` sampled while idle loads the operands. From the next clock `product` reads `{WIDTH zeros, multiplier}`: the upper half is cleared and the lower half holds the multiplier.
- R3: A step whose current low accumulator bit is 0 shifts `{accHi, accLo}` right by one place and puts a zero into the top bit.
- R4: A step whose current low accumulator bit is 1 adds the multiplicand to `accHi`. The adder's carry-out becomes the new top bit as the whole accumulator shifts right by one place.
- R5: `done` rises exactly WIDTH clocks after the clock in which the operands were loaded.
- R6: When `done` is high, `product` equals multiplicand × multiplier taken as unsigned numbers. For example, 13 × 11 gives 143 at WIDTH = 4.
- R7: `done` is high for exactly one clock per accepted start.
- R8: `start` has no effect while a multiplication is running or while `done` is high. The result and its timing are those of the operands that were accepted.
- R9: While idle with `start` low, `product` holds its value whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| multiplicand | input | WIDTH | Operand that is added on each 1 bit |
| multiplier | input | WIDTH | Operand that is scanned from the LSB up |
| product | output | 2*WIDTH | Accumulator `{accHi, accLo}`; the final product once `done` is high |
| done | output | 1 | One-clock flag marking a finished product |

## Verification
The assertions take `start` to be a level that is sampled only at rising edges. They also take the operand inputs to matter only in the clock where `start` is accepted. When the block is idle they place no constraint on the operands or on how long `start` is held. The stimulus changes operands and `start` only on falling edges and holds `start` high for a single clock per request. It also fires deliberate extra `start` pulses, with different operands, while a multiplication is running and during the `done` clock. This shows that the checker's step counting and the bench's expected result both follow the operands that were accepted.

// File: rtl/sam_pkg.sv
package sam_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } samState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;  // capture operands, clear upper half
    logic step;  // one add-or-skip plus right shift
  } samStrb_t;

endpackage

// File: rtl/sam_adder.sv
module sam_adder #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);

  logic [WIDTH:0] carry;

  assign carry[0] = 1'b0;

  genvar bitIdx;
  generate
    for (bitIdx = 0; bitIdx < WIDTH; bitIdx++) begin : g_fa
      logic halfSum;
      assign halfSum          = opA[bitIdx] ^ opB[bitIdx];
      assign sum[bitIdx]      = halfSum ^ carry[bitIdx];
      assign carry[bitIdx+1]  = (opA[bitIdx] & opB[bitIdx]) | (halfSum & carry[bitIdx]);
    end
  endgenerate

  assign carryOut = carry[WIDTH];

endmodule

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import sam_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output samStrb_t strb,
  output logic     done
);

  localparam int               CNT_W    = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

  samState_e        state, stateNxt;
  logic [CNT_W-1:0] stepCnt, stepCntNxt;

  always_comb begin
    stateNxt   = state;
    stepCntNxt = stepCnt;
    strb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load  = 1'b1;
          stepCntNxt = '0;
          stateNxt   = ST_RUN;
        end
      end
      ST_RUN: begin
        strb.step = 1'b1;
        if (stepCnt == LAST_CNT) begin
          stateNxt = ST_DONE;
        end else begin
          stepCntNxt = stepCnt + 1'b1;
        end
      end
      ST_DONE: begin
        stateNxt = ST_IDLE;
      end
      default: begin
        stateNxt = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      state   <= stateNxt;
      stepCnt <= stepCntNxt;
    end
  end

  assign done = (state == ST_DONE);

endmodule

// File: rtl/sam_dpath.sv
module sam_dpath
  import sam_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  samStrb_t           strb,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product
);

  logic [WIDTH-1:0] mcandReg;
  logic [WIDTH-1:0] accHi;
  logic [WIDTH-1:0] accLo;

  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] sum;
  logic             carryOut;
  logic             carryBit;

  // Add/skip decision comes from the bit now at the bottom of accLo
  assign addend = accLo[0] ? mcandReg : '0;

  sam_adder #(.WIDTH(WIDTH)) u_adder (
    .opA      (accHi),
    .opB      (addend),
    .sum      (sum),
    .carryOut (carryOut)
  );

  // carry position: captured carry on an add, zero on a skip
  assign carryBit = accLo[0] & carryOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcandReg <= '0;
      accHi    <= '0;
      accLo    <= '0;
    end else if (strb.load) begin
      mcandReg <= multiplicand;
      accHi    <= '0;
      accLo    <= multiplier;
    end else if (strb.step) begin
      // {carry, sum, accLo} shifted right one place; carry slot refills with zero
      accHi <= {carryBit, sum[WIDTH-1:1]};
      accLo <= {sum[0], accLo[WIDTH-1:1]};
    end
  end

  assign product = {accHi, accLo};

endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
  import sam_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product,
  output logic               done
);

  samStrb_t strb;

  sam_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .done  (done)
  );

  sam_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product)
  );

endmodule

// File: rtl/shift_add_mult_chk.sv
module shift_add_mult_chk
  import sam_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [WIDTH-1:0]   multiplier,
  input logic [2*WIDTH-1:0] product,
  input logic               done,
  input samStrb_t           strb
);

  localparam int SC_W = $clog2(WIDTH + 1) + 1;

  logic [SC_W-1:0] stepsSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepsSeen <= '0;
    end else if (strb.load) begin
      stepsSeen <= '0;
    end else if (strb.step) begin
      stepsSeen <= stepsSeen + 1'b1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rstN |=> (product == '0 && !done));

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> product == {{WIDTH{1'b0}}, $past(multiplier)});

  // R3
  skip_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !product[0]) |=> product == ($past(product) >> 1));

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (stepsSeen == SC_W'(WIDTH)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  no_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step || done) |-> !strb.load);

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.step}));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step && !start) |=> $stable(product));

endmodule

bind shift_add_mult shift_add_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .multiplier (multiplier),
  .product    (product),
  .done       (done),
  .strb       (strb)
);

// File: tb/shift_add_mult_bench.sv
module shift_add_mult_bench;

  localparam int WIDTH   = 4;
  localparam int PW      = 2 * WIDTH;
  localparam int CLK_PER = 10;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [WIDTH-1:0] multiplicand = '0;
  logic [WIDTH-1:0] multiplier = '0;
  logic [PW-1:0]    product;
  logic             done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  shift_add_mult #(.WIDTH(WIDTH)) u_shift_add_mult (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product),
    .done         (done)
  );

  function automatic logic [PW-1:0] fullProduct(logic [WIDTH-1:0] m, logic [WIDTH-1:0] q);
    return PW'(m) * PW'(q);
  endfunction

  // accumulator after the first step, from A = 0, Q = q
  function automatic logic [PW-1:0] firstStep(logic [WIDTH-1:0] m, logic [WIDTH-1:0] q);
    logic [PW:0] wide;
    wide = {1'b0, (q[0] ? m : {WIDTH{1'b0}}), q};
    return wide[PW:1];
  endfunction

  task automatic check(bit ok, string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // pokeRun: extra start while running; pokeDone: extra start during done clock
  task automatic runOp(logic [WIDTH-1:0] m, logic [WIDTH-1:0] q, bit pokeRun, bit pokeDone);
    logic [PW-1:0] want;
    want = fullProduct(m, q);
    @(negedge clk);
    multiplicand = m;
    multiplier   = q;
    start        = 1'b1;
    @(negedge clk);              // load edge has passed
    start = 1'b0;
    check(product == {{WIDTH{1'b0}}, q}, "R2", product, {{WIDTH{1'b0}}, q});
    for (int n = 1; n <= WIDTH; n++) begin
      @(negedge clk);
      if (n == 1) begin
        if (q[0]) check(product == firstStep(m, q), "R4", product, firstStep(m, q));
        else      check(product == firstStep(m, q), "R3", product, firstStep(m, q));
        if (pokeRun && WIDTH > 1) begin
          multiplicand = ~m;
          multiplier   = ~q;
          start        = 1'b1;
        end
      end else begin
        start = 1'b0;
      end
      if (n < WIDTH) begin
        check(!done, "R5", PW'(done), '0);
      end
    end
    check(done == 1'b1, "R5", PW'(done), PW'(1));
    check(product == want, "R6", product, want);
    if (pokeDone) begin
      multiplicand = ~m;
      multiplier   = m;
      start        = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    check(!done, "R7", PW'(done), '0);
    if (pokeDone) check(product == want, "R8", product, want);
    multiplicand = multiplicand + 1'b1;
    multiplier   = multiplier ^ {WIDTH{1'b1}};
    @(negedge clk);
    check(product == want, "R9", product, want);
    check(!done, "R7", PW'(done), '0);
  endtask

  initial begin
    repeat (CLK_PER * 200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    @(negedge clk);
    // R1: reset state
    check(product == '0 && !done, "R1", product, '0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(product == '0 && !done, "R1", product, '0);

    // R6 directed corners
    runOp(4'd13, 4'd11, 1'b0, 1'b0);
    runOp(4'd15, 4'd15, 1'b0, 1'b0);
    runOp(4'd0,  4'd15, 1'b0, 1'b0);
    runOp(4'd15, 4'd0,  1'b0, 1'b0);
    runOp(4'd1,  4'd8,  1'b0, 1'b0);
    // R8 extra starts while busy and during done
    runOp(4'd13, 4'd11, 1'b1, 1'b1);
    runOp(4'd9,  4'd6,  1'b1, 1'b0);

    // R6 every operand pair
    for (int a = 0; a < (1 << WIDTH); a++) begin
      for (int b = 0; b < (1 << WIDTH); b++) begin
        runOp(WIDTH'(a), WIDTH'(b), 1'b0, 1'b0);
      end
    end

    // random mix with busy pokes
    for (int k = 0; k < 60; k++) begin
      runOp(WIDTH'($urandom), WIDTH'($urandom), 1'($urandom), 1'($urandom));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule